// File: doc/BRIEF.md
# Register-Dump Trace Record Serializer

This block carries out one explicit trace request. When it is idle and `start` is raised, it takes a snapshot of the 48-bit time-of-day value, the 32-bit trace operand and the register range. It then sends a trace record of variable length, one 32-bit word per cycle, on a write port. The record begins with a header word that holds a format code together with the number of registers, minus one. The remaining 32 clock bits follow, then the operand, and then the low 32 bits of each general register in the range.

The register range is set by a first and a last 4-bit register number and wraps from 15 back to 0. The block reads each register through a register-file read port. That port has a 4-bit address output, and the data comes back combinationally in the same cycle. After the last register word the block raises a one-cycle `done` and shows the length of the record in bytes. An optional fast-clock mode can blank one byte of the operand before it is written.

Top module: `trc_dump`

## Requirements
- R1: While reset is held, and after it is released with no request made, `busy`, `wr_valid` and `done` are 0.
- R2: The register count minus one, n, is last_reg − first_reg when last_reg ≥ first_reg, and last_reg + 16 − first_reg otherwise. The first word is written in the cycle after `start` is accepted. Its bits 31:24 equal 0x70 OR n, and its bits 23:16 are 0x00.
- R3: The header's bits 15:0 carry `tod_lo[47:32]`, and the second word carries `tod_lo[31:0]`. Both come from the value present in the cycle in which `start` is accepted, so later changes to `tod_lo` have no effect on them.
- R4: The third word is the operand captured when `start` is accepted.
- R5: If `fast_en` and `fast_ctl` are both 1 when `start` is accepted, operand bits 23:16 are written as zero. Otherwise the operand is written unchanged.
- R6: The register words begin at first_reg and step by one modulo 16, ending after last_reg. While each one is written, `rf_addr` holds the register number of that word.
- R7: When first_reg equals last_reg, exactly one register word is written and n is 0.
- R8: The record is 4 + n words on consecutive cycles. `done` is high for exactly the one cycle after the last word. At that point `rec_len` equals 12 + 4×(n+1) bytes (76 for all 16 registers), and it keeps that value until the next request is accepted.
- R9: A `start` raised while `busy` is 1 is ignored and does not alter the record in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only when idle |
| first_reg | input | 4 | First register number of the range |
| last_reg | input | 4 | Last register number of the range |
| operand | input | 32 | Trace operand |
| fast_en | input | 1 | Fast-clock option is available |
| fast_ctl | input | 1 | Fast-clock control bit |
| tod_lo | input | 48 | Low 48 bits of the time-of-day counter |
| rf_addr | output | 4 | Register-file read address |
| rf_data | input | 32 | Register-file read data (same cycle) |
| wr_valid | output | 1 | Record word valid on `wr_data` |
| wr_data | output | 32 | Record word |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-record pulse |
| rec_len | output | 7 | Record length in bytes |

## Verification
Some properties are checked by assertions on every cycle. These cover the format byte and zero byte of the header word in the first busy cycle, and the rule that no word is written while the block is idle. They also cover the single-cycle `done` with no word alongside it, agreement between `rec_len` and the number of words actually written, and `rf_addr` advancing by one (mod 16) across consecutive register words. Other behaviour depends on values outside the block, so only the bench scenarios can show it. This includes whether the clock and operand come from the snapshot, whether the fast-mode byte masking is correct, whether the register contents match the register file, whether the wrap points are right, and whether a late `start` is ignored.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_TOD  = 3'd2,
    ST_OPND = 3'd3,
    ST_REGS = 3'd4,
    ST_DONE = 3'd5
  } trc_state_e;
endpackage

// File: rtl/trc_range.sv
module trc_range #(
  parameter int REG_AW    = 4,
  parameter int LEN_W     = 7,
  parameter int FIX_BYTES = 12,
  parameter int WORD_B    = 4
) (
  input  logic [REG_AW-1:0] first_reg,
  input  logic [REG_AW-1:0] last_reg,
  output logic [REG_AW-1:0] cnt_m1,
  output logic [LEN_W-1:0]  len_bytes
);
  localparam int NREG = 1 << REG_AW;
  localparam int SUM_W = REG_AW + 1;

  logic [SUM_W-1:0] span;

  always_comb begin
    if (last_reg >= first_reg)
      span = SUM_W'(last_reg) - SUM_W'(first_reg);
    else
      span = SUM_W'(last_reg) + SUM_W'(NREG) - SUM_W'(first_reg);
    cnt_m1    = span[REG_AW-1:0];
    len_bytes = LEN_W'(FIX_BYTES) + LEN_W'(WORD_B) * (LEN_W'(cnt_m1) + LEN_W'(1));
  end
endmodule

// File: rtl/trc_snap.sv
module trc_snap #(
  parameter int DATA_W   = 32,
  parameter int TOD_W    = 48,
  parameter int REG_AW   = 4,
  parameter logic [7:0] FMT_CODE = 8'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [REG_AW-1:0] cnt_m1,
  input  logic [DATA_W-1:0] operand,
  input  logic              fast_en,
  input  logic              fast_ctl,
  input  logic [TOD_W-1:0]  tod_lo,
  output logic [DATA_W-1:0] hdr_word,
  output logic [DATA_W-1:0] tod_word,
  output logic [DATA_W-1:0] opnd_word
);
  localparam int HDR_TOD_W = TOD_W - DATA_W;
  localparam logic [DATA_W-1:0] CLR_MASK = ~(DATA_W'(8'hFF) << (DATA_W - 16));

  logic [DATA_W-1:0] hdr_d, tod_d, opnd_d;
  logic [DATA_W-1:0] hdr_q, tod_q, opnd_q;

  always_comb begin
    hdr_d  = hdr_q;
    tod_d  = tod_q;
    opnd_d = opnd_q;
    if (capture) begin
      hdr_d  = {FMT_CODE | 8'(cnt_m1), 8'h00, tod_lo[TOD_W-1 -: HDR_TOD_W]};
      tod_d  = tod_lo[DATA_W-1:0];
      opnd_d = (fast_en && fast_ctl) ? (operand & CLR_MASK) : operand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= '0;
      tod_q  <= '0;
      opnd_q <= '0;
    end else if (capture) begin
      hdr_q  <= hdr_d;
      tod_q  <= tod_d;
      opnd_q <= opnd_d;
    end
  end

  assign hdr_word  = hdr_q;
  assign tod_word  = tod_q;
  assign opnd_word = opnd_q;
endmodule

// File: rtl/trc_seq.sv
module trc_seq
  import trc_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REG_AW-1:0] first_reg,
  input  logic [REG_AW-1:0] cnt_m1,
  input  logic [LEN_W-1:0]  len_in,
  output logic              capture,
  output trc_state_e        state,
  output logic [REG_AW-1:0] ptr,
  output logic [LEN_W-1:0]  rec_len
);
  trc_state_e        state_d, state_q;
  logic [REG_AW-1:0] ptr_d, ptr_q;
  logic [REG_AW-1:0] rem_d, rem_q;
  logic [LEN_W-1:0]  len_d, len_q;

  assign capture = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    len_d   = len_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_HDR;
        ptr_d   = first_reg;
        rem_d   = cnt_m1;
        len_d   = len_in;
      end
      ST_HDR:  state_d = ST_TOD;
      ST_TOD:  state_d = ST_OPND;
      ST_OPND: state_d = ST_REGS;
      ST_REGS: begin
        if (rem_q == '0) begin
          state_d = ST_DONE;
        end else begin
          ptr_d = ptr_q + REG_AW'(1);
          rem_d = rem_q - REG_AW'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      rem_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      len_q   <= len_d;
    end
  end

  assign state   = state_q;
  assign ptr     = ptr_q;
  assign rec_len = len_q;
endmodule

// File: rtl/trc_dump.sv
module trc_dump
  import trc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TOD_W  = 48,
  parameter int REG_AW = 4,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REG_AW-1:0] first_reg,
  input  logic [REG_AW-1:0] last_reg,
  input  logic [DATA_W-1:0] operand,
  input  logic              fast_en,
  input  logic              fast_ctl,
  input  logic [TOD_W-1:0]  tod_lo,
  output logic [REG_AW-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_data,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  rec_len
);
  localparam int WORD_B    = DATA_W / 8;
  localparam int FIX_BYTES = 3 * WORD_B;

  logic [REG_AW-1:0] cnt_m1;
  logic [LEN_W-1:0]  len_bytes;
  logic              capture;
  trc_state_e        state;
  logic [REG_AW-1:0] ptr;
  logic [DATA_W-1:0] hdr_word, tod_word, opnd_word;

  trc_range #(
    .REG_AW(REG_AW), .LEN_W(LEN_W), .FIX_BYTES(FIX_BYTES), .WORD_B(WORD_B)
  ) u_range (
    .first_reg(first_reg), .last_reg(last_reg),
    .cnt_m1(cnt_m1), .len_bytes(len_bytes)
  );

  trc_seq #(.REG_AW(REG_AW), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .first_reg(first_reg),
    .cnt_m1(cnt_m1), .len_in(len_bytes), .capture(capture),
    .state(state), .ptr(ptr), .rec_len(rec_len)
  );

  trc_snap #(.DATA_W(DATA_W), .TOD_W(TOD_W), .REG_AW(REG_AW)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cnt_m1(cnt_m1),
    .operand(operand), .fast_en(fast_en), .fast_ctl(fast_ctl),
    .tod_lo(tod_lo), .hdr_word(hdr_word), .tod_word(tod_word),
    .opnd_word(opnd_word)
  );

  always_comb begin
    wr_valid = 1'b1;
    wr_data  = '0;
    unique case (state)
      ST_HDR:  wr_data = hdr_word;
      ST_TOD:  wr_data = tod_word;
      ST_OPND: wr_data = opnd_word;
      ST_REGS: wr_data = rf_data;
      default: wr_valid = 1'b0;
    endcase
  end

  assign rf_addr = ptr;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
endmodule

// File: rtl/trc_dump_chk.sv
module trc_dump_chk #(
  parameter int REG_AW = 4,
  parameter int LEN_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wr_valid,
  input logic [15:0]       hdr_top,
  input logic              done,
  input logic [LEN_W-1:0]  rec_len,
  input logic [REG_AW-1:0] rf_addr
);
  logic [7:0]        words_q;
  logic              prev_reg_q;
  logic [REG_AW-1:0] prev_addr_q;
  logic              reg_word;

  assign reg_word = wr_valid && (words_q >= 8'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q     <= '0;
      prev_reg_q  <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      if (done)          words_q <= '0;
      else if (wr_valid) words_q <= words_q + 8'd1;
      prev_reg_q  <= reg_word;
      prev_addr_q <= rf_addr;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !done));

  assert_header_format_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (wr_valid && hdr_top[15:12] == 4'h7 && hdr_top[7:0] == 8'h00));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word && prev_reg_q) |-> (rf_addr == prev_addr_q + REG_AW'(1)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_no_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

  assert_len_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rec_len == LEN_W'({words_q, 2'b00})));
endmodule

bind trc_dump trc_dump_chk #(.REG_AW(REG_AW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_valid(wr_valid),
  .hdr_top(wr_data[DATA_W-1 -: 16]), .done(done), .rec_len(rec_len),
  .rf_addr(rf_addr)
);

// File: tb/trc_dump_tb.sv
module trc_dump_tb;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  first_reg, last_reg;
  logic [31:0] operand;
  logic        fast_en, fast_ctl;
  logic [47:0] tod_lo;
  logic [3:0]  rf_addr;
  logic [31:0] rf_data;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic        busy, done;
  logic [6:0]  rec_len;

  logic [31:0] gpr [16];
  int n_checks = 0;
  int n_fail   = 0;

  assign rf_data = gpr[rf_addr];

  trc_dump u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_reg(first_reg),
    .last_reg(last_reg), .operand(operand), .fast_en(fast_en),
    .fast_ctl(fast_ctl), .tod_lo(tod_lo), .rf_addr(rf_addr),
    .rf_data(rf_data), .wr_valid(wr_valid), .wr_data(wr_data),
    .busy(busy), .done(done), .rec_len(rec_len)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int span_of(input logic [3:0] a, input logic [3:0] b);
    return (b >= a) ? int'(b) - int'(a) : int'(b) + 16 - int'(a);
  endfunction

  task automatic run_rec(input logic [3:0] r1, input logic [3:0] r3,
                         input logic [31:0] op, input bit fe, input bit fc,
                         input bit late_start);
    int n;
    int nw;
    int k;
    bit gap;
    bit seen_done;
    logic [47:0] snap_tod;
    logic [31:0] exp_op;
    logic [31:0] w [32];
    logic [3:0]  a [32];
    n = span_of(r1, r3);
    for (int i = 0; i < 16; i++) gpr[i] = $urandom;
    @(negedge clk);
    first_reg = r1; last_reg = r3; operand = op;
    fast_en = fe; fast_ctl = fc;
    tod_lo = {$urandom, $urandom};
    snap_tod = tod_lo;
    start = 1'b1;
    nw = 0; gap = 1'b0; seen_done = 1'b0;
    for (int cyc = 0; cyc < 40 && !seen_done; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        start = 1'b0;
        operand = ~op;
        first_reg = r1 + 4'd5;
        last_reg = r3 + 4'd2;
        fast_en = ~fe;
      end
      if (late_start && cyc == 2) start = 1'b1;
      if (late_start && cyc == 3) start = 1'b0;
      if (wr_valid && nw < 32) begin
        w[nw] = wr_data; a[nw] = rf_addr; nw++;
      end else if (done) begin
        seen_done = 1'b1;
      end else begin
        gap = 1'b1;
      end
      tod_lo = {$urandom, $urandom};
    end
    exp_op = (fe && fc) ? (op & 32'hFF00_FFFF) : op;
    chk(seen_done && !gap, "R8 contiguous words then done", 32'(gap), 32'd0);
    chk(nw == n + 4, "R8 word count", 32'(nw), 32'(n + 4));
    chk(w[0][31:16] == {8'h70 | 8'(n), 8'h00}, "R2 header format/count",
        {16'h0, w[0][31:16]}, {16'h0, 8'h70 | 8'(n), 8'h00});
    chk(w[0][15:0] == snap_tod[47:32], "R3 header clock bits",
        {16'h0, w[0][15:0]}, {16'h0, snap_tod[47:32]});
    chk(w[1] == snap_tod[31:0], "R3 clock low word", w[1], snap_tod[31:0]);
    chk(w[2] == exp_op, "R4/R5 operand word", w[2], exp_op);
    for (int j = 0; j <= n && j + 3 < nw; j++) begin
      k = (int'(r1) + j) % 16;
      chk(w[j+3] == gpr[k] && a[j+3] == 4'(k), "R6 register word",
          w[j+3], gpr[k]);
    end
    chk(rec_len == 7'(12 + 4 * (n + 1)), "R8 length at done",
        32'(rec_len), 32'(12 + 4 * (n + 1)));
    @(negedge clk);
    chk(!busy && !wr_valid && rec_len == 7'(12 + 4 * (n + 1)),
        "R8 idle with length held", 32'(rec_len), 32'(12 + 4 * (n + 1)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; first_reg = '0; last_reg = '0;
    operand = '0; fast_en = 1'b0; fast_ctl = 1'b0; tod_lo = '0;
    for (int i = 0; i < 16; i++) gpr[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !wr_valid && !done, "R1 in reset", {29'h0, busy, wr_valid, done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !wr_valid && !done, "R1 after reset", {29'h0, busy, wr_valid, done}, 32'h0);

    run_rec(4'd3, 4'd3, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0);   // R7 single register
    chk(1'b1, "R7 single register record run", 32'h0, 32'h0);
    run_rec(4'd0, 4'd15, 32'h1234_5678, 1'b0, 1'b0, 1'b0);  // R8 76-byte record
    run_rec(4'd15, 4'd0, 32'hCAFE_F00D, 1'b0, 1'b0, 1'b0);  // R2 wrap n=1
    run_rec(4'd9, 4'd8, 32'h0F0F_0F0F, 1'b0, 1'b0, 1'b0);   // R6 full wrap
    run_rec(4'd2, 4'd6, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);   // R5 masked
    run_rec(4'd2, 4'd6, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);   // R5 ctl off
    run_rec(4'd2, 4'd6, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);   // R5 option off
    run_rec(4'd12, 4'd1, 32'hA5A5_5A5A, 1'b0, 1'b0, 1'b1);  // R9 late start
    for (int t = 0; t < 40; t++) begin
      run_rec(4'($urandom), 4'($urandom), $urandom, 1'($urandom), 1'($urandom),
              1'($urandom));
    end
    repeat (2) @(negedge clk);
    chk(!busy && !wr_valid, "R9 no stray record", {30'h0, busy, wr_valid}, 32'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule